// File: doc/BRIEF.md
# Product Term Allocator and Pin Router

This block sits between a wide AND plane and a bank of macrocells. The AND plane delivers its product terms as one flat bus. A latched configuration decides which OR gate each term feeds. Any OR gate may therefore collect between zero and sixteen terms from a shared pool, and no gate has a fixed allotment.

Each macrocell output is either its OR sum or the value of its external flip-flop, chosen per macrocell by a configuration bit. All macrocell outputs return on a feedback bus at all times. A second configuration table routes any macrocell to any I/O pin. A pin that no macrocell drives has its output enable low, and its pad value is passed inward, so a buried macrocell keeps feeding back while its pin serves as an input.

The whole configuration is presented at once and captured on a single `cfg_load` cycle. A configuration is checked before capture, and an illegal one is refused. All data paths are combinational from the current terms, flip-flop values and pads.

Top module: `pterm_router`

## Requirements
- R1: `or_sum[g]` is the OR of every `pterm[t]` whose bit `cfg_term_mask[g*NUM_TERMS+t]` was set in the accepted configuration.
- R2: A gate may receive any count of terms from 0 to 16 inclusive. A gate whose accepted mask is empty outputs 0 for every term pattern.
- R3: A load in which some term is set in the masks of two or more gates is refused. `cfg_err` becomes 1 on the next edge and the previous configuration stays in force.
- R4: A load in which any gate's mask holds more than 16 terms is refused in the same way as R3.
- R5: An accepted load clears `cfg_err`. The new configuration governs the outputs from the clock edge that samples `cfg_load` onward. During the load cycle itself the old one still applies. Without `cfg_load`, both the configuration and `cfg_err` hold.
- R6: Each pin has a 6-bit select field at `cfg_pin_sel[p*6 +: 6]`. Bit 5 is the enable and bits 4:0 are the macrocell index. An enabled pin drives that macrocell's output with `pin_oe` at 1. Any macrocell may reach any pin, and several pins may share one macrocell.
- R7: The output of macrocell m is `mc_ff_q[m]` when its latched `cfg_mc_reg[m]` bit is 1, and `or_sum[m]` otherwise. `mc_fb` always carries all macrocell outputs, whether or not a pin is routed to them.
- R8: On a pin that is not enabled, `pin_oe` is 0, `pin_out` is 0 and `pin_rx` equals `pin_in`. On an enabled pin, `pin_rx` is 0.
- R9: After reset every mask, mode bit and pin select is zero and `cfg_err` is 0. As a result, all sums are 0 and no pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the presented configuration this cycle |
| cfg_term_mask | input | NUM_GATES*NUM_TERMS | Term-to-gate masks, gate-major |
| cfg_mc_reg | input | NUM_GATES | Per-macrocell output source, 1 = flip-flop |
| cfg_pin_sel | input | NUM_PINS*6 | Per-pin enable and macrocell index |
| pterm | input | NUM_TERMS | Product terms from the AND plane |
| mc_ff_q | input | NUM_GATES | Flip-flop outputs of the macrocells |
| pin_in | input | NUM_PINS | Pad input values |
| or_sum | output | NUM_GATES | OR gate results |
| mc_fb | output | NUM_GATES | Macrocell feedback bus |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_rx | output | NUM_PINS | Pad values passed inward for undriven pins |
| cfg_err | output | 1 | Last load was refused |

## Verification
A configuration load and a change of the product terms can happen in the same cycle. The bench applies new terms, flip-flop values and pads on the very cycle it raises `cfg_load`. Before the edge it compares every output against the old configuration, and after the edge it compares them against the new one, or against the old one again if the load was refused. Legal and illegal loads are interleaved so that refusal is also seen to hold the routing steady while the data keeps moving.

// File: rtl/pterm_router_pkg.sv
package pterm_router_pkg;
  localparam int unsigned DEF_TERMS    = 80;
  localparam int unsigned DEF_GATES    = 32;
  localparam int unsigned DEF_PINS     = 16;
  localparam int unsigned DEF_MAX_FANIN = 16;
endpackage

// File: rtl/pterm_cfg_check.sv
module pterm_cfg_check #(
  parameter int unsigned NUM_TERMS = 80,
  parameter int unsigned NUM_GATES = 32,
  parameter int unsigned MAX_FANIN = 16
) (
  input  logic [NUM_GATES*NUM_TERMS-1:0] mask,
  output logic                           shared,
  output logic                           overfull
);
  localparam int unsigned CW = $clog2(NUM_TERMS + 1);

  always_comb begin
    logic [NUM_TERMS-1:0] claimed;
    logic [CW-1:0]        cnt;
    claimed  = '0;
    shared   = 1'b0;
    overfull = 1'b0;
    for (int g = 0; g < NUM_GATES; g++) begin
      cnt = '0;
      for (int t = 0; t < NUM_TERMS; t++) begin
        cnt = cnt + CW'(mask[g*NUM_TERMS + t]);
      end
      if (cnt > CW'(MAX_FANIN)) overfull = 1'b1;
      if (|(claimed & mask[g*NUM_TERMS +: NUM_TERMS])) shared = 1'b1;
      claimed = claimed | mask[g*NUM_TERMS +: NUM_TERMS];
    end
  end
endmodule

// File: rtl/pterm_or_array.sv
module pterm_or_array #(
  parameter int unsigned NUM_TERMS = 80,
  parameter int unsigned NUM_GATES = 32
) (
  input  logic [NUM_GATES*NUM_TERMS-1:0] mask,
  input  logic [NUM_TERMS-1:0]           pterm,
  output logic [NUM_GATES-1:0]           or_sum
);
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign or_sum[g] = |(mask[g*NUM_TERMS +: NUM_TERMS] & pterm);
  end
endmodule

// File: rtl/pterm_out_switch.sv
module pterm_out_switch #(
  parameter int unsigned NUM_GATES = 32,
  parameter int unsigned NUM_PINS  = 16,
  localparam int unsigned MCW  = $clog2(NUM_GATES),
  localparam int unsigned SELW = MCW + 1
) (
  input  logic [NUM_GATES-1:0]     mc_out,
  input  logic [NUM_PINS*SELW-1:0] pin_sel,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_PINS-1:0]      pin_oe,
  output logic [NUM_PINS-1:0]      pin_rx
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SELW-1:0] sel;
    logic            en;
    assign sel        = pin_sel[p*SELW +: SELW];
    assign en         = sel[SELW-1];
    assign pin_oe[p]  = en;
    assign pin_out[p] = en & mc_out[sel[MCW-1:0]];
    assign pin_rx[p]  = ~en & pin_in[p];
  end
endmodule

// File: rtl/pterm_router.sv
module pterm_router
  import pterm_router_pkg::*;
#(
  parameter int unsigned NUM_TERMS = DEF_TERMS,
  parameter int unsigned NUM_GATES = DEF_GATES,
  parameter int unsigned NUM_PINS  = DEF_PINS,
  parameter int unsigned MAX_FANIN = DEF_MAX_FANIN,
  localparam int unsigned MCW  = $clog2(NUM_GATES),
  localparam int unsigned SELW = MCW + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_load,
  input  logic [NUM_GATES*NUM_TERMS-1:0] cfg_term_mask,
  input  logic [NUM_GATES-1:0]           cfg_mc_reg,
  input  logic [NUM_PINS*SELW-1:0]       cfg_pin_sel,
  input  logic [NUM_TERMS-1:0]           pterm,
  input  logic [NUM_GATES-1:0]           mc_ff_q,
  input  logic [NUM_PINS-1:0]            pin_in,
  output logic [NUM_GATES-1:0]           or_sum,
  output logic [NUM_GATES-1:0]           mc_fb,
  output logic [NUM_PINS-1:0]            pin_out,
  output logic [NUM_PINS-1:0]            pin_oe,
  output logic [NUM_PINS-1:0]            pin_rx,
  output logic                           cfg_err
);
  logic [NUM_GATES*NUM_TERMS-1:0] term_mask_q;
  logic [NUM_GATES-1:0]           mc_reg_q;
  logic [NUM_PINS*SELW-1:0]       pin_sel_q;
  logic                           cfg_shared;
  logic                           cfg_overfull;
  logic                           cfg_ok;
  logic [NUM_GATES-1:0]           mc_out;

  pterm_cfg_check #(
    .NUM_TERMS(NUM_TERMS), .NUM_GATES(NUM_GATES), .MAX_FANIN(MAX_FANIN)
  ) u_check (
    .mask(cfg_term_mask), .shared(cfg_shared), .overfull(cfg_overfull)
  );

  assign cfg_ok = ~cfg_shared & ~cfg_overfull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_mask_q <= '0;
      mc_reg_q    <= '0;
      pin_sel_q   <= '0;
      cfg_err     <= 1'b0;
    end else if (cfg_load) begin
      cfg_err <= ~cfg_ok;
      if (cfg_ok) begin
        term_mask_q <= cfg_term_mask;
        mc_reg_q    <= cfg_mc_reg;
        pin_sel_q   <= cfg_pin_sel;
      end
    end
  end

  pterm_or_array #(
    .NUM_TERMS(NUM_TERMS), .NUM_GATES(NUM_GATES)
  ) u_or (
    .mask(term_mask_q), .pterm(pterm), .or_sum(or_sum)
  );

  assign mc_out = (mc_reg_q & mc_ff_q) | (~mc_reg_q & or_sum);
  assign mc_fb  = mc_out;

  pterm_out_switch #(
    .NUM_GATES(NUM_GATES), .NUM_PINS(NUM_PINS)
  ) u_sw (
    .mc_out(mc_out), .pin_sel(pin_sel_q), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_rx(pin_rx)
  );
endmodule

// File: rtl/pterm_router_sva.sv
module pterm_router_sva #(
  parameter int unsigned NUM_TERMS = 80,
  parameter int unsigned NUM_GATES = 32,
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned MAX_FANIN = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cfg_load,
  input logic [NUM_GATES*NUM_TERMS-1:0] mask_q,
  input logic [NUM_GATES-1:0]           or_sum,
  input logic [NUM_PINS-1:0]            pin_out,
  input logic [NUM_PINS-1:0]            pin_oe,
  input logic [NUM_PINS-1:0]            pin_rx,
  input logic                           cfg_err
);
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_col
    logic [NUM_GATES-1:0] col;
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_bit
      assign col[g] = mask_q[g*NUM_TERMS + t];
    end
    AST_TERM_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col)); // R3
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_fan
    AST_FANIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $countones(mask_q[g*NUM_TERMS +: NUM_TERMS]) <= MAX_FANIN); // R4
    AST_EMPTY_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (mask_q[g*NUM_TERMS +: NUM_TERMS] == '0) |-> !or_sum[g]); // R2
  end

  AST_REFUSED_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n) cfg_load |=> (!cfg_err || $stable(mask_q))); // R3
  AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n) !cfg_load |=> ($stable(mask_q) && $stable(cfg_err))); // R5
  AST_UNDRIVEN_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) (pin_out & ~pin_oe) == '0); // R8
  AST_DRIVEN_PIN_NO_RX: assert property (@(posedge clk) disable iff (!rst_n) (pin_rx & pin_oe) == '0); // R8
endmodule

bind pterm_router pterm_router_sva #(
  .NUM_TERMS(NUM_TERMS), .NUM_GATES(NUM_GATES),
  .NUM_PINS(NUM_PINS), .MAX_FANIN(MAX_FANIN)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .mask_q(term_mask_q),
  .or_sum(or_sum), .pin_out(pin_out), .pin_oe(pin_oe), .pin_rx(pin_rx),
  .cfg_err(cfg_err)
);

// File: tb/pterm_router_bench.sv
`timescale 1ns/1ps
module pterm_router_bench;
  localparam int T = 80;
  localparam int G = 32;
  localparam int P = 16;
  localparam int SW = 6;
  localparam int MAXF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [G*T-1:0] cfg_term_mask = '0;
  logic [G-1:0]   cfg_mc_reg = '0;
  logic [P*SW-1:0] cfg_pin_sel = '0;
  logic [T-1:0]   pterm = '0;
  logic [G-1:0]   mc_ff_q = '0;
  logic [P-1:0]   pin_in = '0;
  logic [G-1:0]   or_sum, mc_fb;
  logic [P-1:0]   pin_out, pin_oe, pin_rx;
  logic           cfg_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [G*T-1:0]  m_mask = '0;
  logic [G-1:0]    m_reg = '0;
  logic [P*SW-1:0] m_sel = '0;
  logic            m_err = 1'b0;

  always #4 clk = ~clk;

  pterm_router u_pterm_router (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_term_mask(cfg_term_mask),
    .cfg_mc_reg(cfg_mc_reg), .cfg_pin_sel(cfg_pin_sel), .pterm(pterm),
    .mc_ff_q(mc_ff_q), .pin_in(pin_in), .or_sum(or_sum), .mc_fb(mc_fb),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_rx(pin_rx), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic legal(input logic [G*T-1:0] mk);
    for (int t = 0; t < T; t++) begin
      int n = 0;
      for (int g = 0; g < G; g++) n += int'(mk[g*T+t]);
      if (n > 1) return 1'b0;
    end
    for (int g = 0; g < G; g++) begin
      int n = 0;
      for (int t = 0; t < T; t++) n += int'(mk[g*T+t]);
      if (n > MAXF) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [G-1:0] e_or(input logic [T-1:0] pt);
    logic [G-1:0] r = '0;
    for (int g = 0; g < G; g++)
      for (int t = 0; t < T; t++)
        if (m_mask[g*T+t] && pt[t]) r[g] = 1'b1;
    return r;
  endfunction

  function automatic logic [G-1:0] e_mc(input logic [T-1:0] pt, input logic [G-1:0] ff);
    logic [G-1:0] o = e_or(pt);
    logic [G-1:0] r;
    for (int g = 0; g < G; g++) r[g] = m_reg[g] ? ff[g] : o[g];
    return r;
  endfunction

  task automatic check_all(input string tag);
    logic [G-1:0] mc = e_mc(pterm, mc_ff_q);
    logic [P-1:0] eo = '0, ee = '0, er = '0;
    for (int p = 0; p < P; p++) begin
      logic [5:0] s = m_sel[p*SW +: SW];
      if (s[5]) begin ee[p] = 1'b1; eo[p] = mc[s[4:0]]; end
      else er[p] = pin_in[p];
    end
    chk({tag, " R1 or_sum"}, 64'(or_sum), 64'(e_or(pterm)));
    chk({tag, " R7 mc_fb"}, 64'(mc_fb), 64'(mc));
    chk({tag, " R6 pin_out"}, 64'(pin_out), 64'(eo));
    chk({tag, " R6 pin_oe"}, 64'(pin_oe), 64'(ee));
    chk({tag, " R8 pin_rx"}, 64'(pin_rx), 64'(er));
    chk({tag, " R5 cfg_err"}, 64'(cfg_err), 64'(m_err));
  endtask

  task automatic rand_data();
    pterm   = {$urandom, $urandom, $urandom};
    mc_ff_q = $urandom;
    pin_in  = P'($urandom);
  endtask

  // Load with data change in the same cycle: old config before edge, new after.
  task automatic load(input logic [G*T-1:0] mk, input logic [G-1:0] rg,
                      input logic [P*SW-1:0] sl, input string tag);
    @(negedge clk);
    cfg_term_mask = mk; cfg_mc_reg = rg; cfg_pin_sel = sl; cfg_load = 1'b1;
    rand_data();
    #1 check_all({tag, " pre-edge R5"});
    @(posedge clk);
    if (legal(mk)) begin m_mask = mk; m_reg = rg; m_sel = sl; m_err = 1'b0; end
    else m_err = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_term_mask = {G*T{1'b1}};
    #1 check_all({tag, " post-edge"});
  endtask

  function automatic logic [P*SW-1:0] rand_sel();
    logic [P*SW-1:0] s;
    for (int p = 0; p < P; p++)
      s[p*SW +: SW] = {($urandom % 4) != 0, 5'($urandom % G)};
    return s;
  endfunction

  function automatic logic [G*T-1:0] rand_mask();
    logic [G*T-1:0] mk = '0;
    int cnt [G];
    for (int g = 0; g < G; g++) cnt[g] = 0;
    for (int t = 0; t < T; t++) begin
      int r = int'($urandom % (G + 8));
      if (r < G && cnt[r] < MAXF) begin mk[r*T+t] = 1'b1; cnt[r]++; end
    end
    return mk;
  endfunction

  initial begin
    logic [G*T-1:0] mk;
    void'($urandom(32'd20241));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    pterm = '1; mc_ff_q = '1; pin_in = 16'hA5C3;
    #1;
    chk("R9 reset or_sum", 64'(or_sum), 64'd0);
    chk("R9 reset pin_oe", 64'(pin_oe), 64'd0);
    chk("R9 reset cfg_err", 64'(cfg_err), 64'd0);
    chk("R9 reset pin_rx", 64'(pin_rx), 64'(16'hA5C3));

    // Directed: gate 0 empty, gate 1 sixteen terms, gate 2 one term
    mk = '0;
    for (int t = 0; t < 16; t++) mk[1*T + t] = 1'b1;
    mk[2*T + 40] = 1'b1;
    load(mk, 32'h0000_0004, {16{6'b100001}}, "R2 fanin16");
    @(negedge clk) pterm = '0; pterm[40] = 1'b1; pterm[15] = 1'b1;
    #1 chk("R2 empty gate low", 64'(or_sum[0]), 64'd0);
    chk("R2 16-term gate", 64'(or_sum[1]), 64'd1);
    check_all("R1 directed");

    // Over fan-in: 17 terms on gate 3
    mk = m_mask;
    for (int t = 50; t < 67; t++) mk[3*T + t] = 1'b1;
    load(mk, '1, '0, "R4 overfull");
    chk("R4 refused", 64'(cfg_err), 64'd1);

    // Shared term: term 40 also on gate 5
    mk = m_mask; mk[5*T + 40] = 1'b1;
    load(mk, '0, '0, "R3 shared");
    chk("R3 refused", 64'(cfg_err), 64'd1);

    // Hold without load
    repeat (3) begin
      @(negedge clk) rand_data();
      #1 check_all("R5 hold");
    end

    // Random legal and illegal loads with data sweeps
    for (int i = 0; i < 60; i++) begin
      mk = rand_mask();
      if (($urandom % 4) == 0) begin
        int t = int'($urandom % T);
        mk[(int'($urandom % G))*T + t] = 1'b1;
        mk[(int'($urandom % G))*T + t] = 1'b1;
      end
      load(mk, $urandom, rand_sel(), "rand");
      for (int k = 0; k < 6; k++) begin
        @(negedge clk) rand_data();
        #1 check_all("rand data");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule